// File: doc/BRIEF.md
# Framed Four-Port Packet Switch

This block moves framed packets between four devices on an accelerator card: the host-side packet mover (port 0), the transmit processing stage (port 1), the Ethernet-side device (port 2) and the receive processing stage (port 3). Routing is fixed and forms a ring. Host traffic goes to the transmit stage. Transmit-stage output goes to the Ethernet side. Ethernet traffic goes to the receive stage. Receive-stage output goes back to the host. Each of the four lanes runs on its own, so both directions carry traffic at the same time.

Every link carries 72-bit words. Each word holds 64 data bits, a start flag, an end flag, a count of valid bytes for the last word, and an abort flag. A small state machine in each lane checks the framing. Words that break the framing are discarded, and the lane resynchronises on the next start flag. If a packet is cut off by a new start flag, the lane closes that packet with an abort terminator, so downstream always sees complete frames. Each input port has a saturating counter of discarded words, and a select input reads these counters.

Each lane has three named states. ST_IDLE means between frames. ST_FRAME means inside a frame. ST_DISCARD means discarding after an error. The transitions are:
- ST_IDLE or ST_DISCARD to ST_FRAME on a start word without an end flag.
- Back to ST_IDLE on a start word that also has an end flag.
- ST_IDLE or ST_DISCARD to ST_DISCARD on any word without a start flag.
- ST_FRAME to ST_IDLE on a non-start word carrying the end flag.
- ST_FRAME to ST_FRAME on any other non-start word.
- ST_FRAME to ST_DISCARD on a start word, which also emits the abort terminator.

Top module: `fsw_switch`

## Requirements
- R1: A word accepted on input k that is forwarded appears on output (k+1) mod 4 and on no other output.
- R2: A forwarded word keeps all 72 bits unchanged. The field positions are: data in bits [63:0], start flag in bit 64, end flag in bit 65, last-word byte count in bits [68:66], abort flag in bit 69, and bits [71:70] reserved. The switch only interprets bits 64 and 65.
- R3: A word with both the start and end flags set is a complete one-word packet. It is forwarded, and the next start word is forwarded as a new packet.
- R4: A word without the start flag that arrives outside a frame is discarded. Every following non-start word on that input is also discarded. The next start word is forwarded.
- R5: A start word arriving inside a frame is discarded. In its place the lane emits an abort terminator: bit 65 = 1, bit 69 = 1, all other bits 0. The lane then discards words until the next start word.
- R6: While an output holds a word with its ready low, the word stays unchanged and valid, and the source input feeding that output has its ready low. When ready returns, the held word leaves and a waiting input word is accepted on the same clock edge.
- R7: A stalled output affects only its own source input. Every output that is empty or ready lets its source input accept.
- R8: An accepted word is on the output after the next rising clock edge. With ready held high, a lane carries one word per cycle.
- R9: Each input port has a CNT_W-bit counter that adds one for every discarded word (R4) and every abort-triggering word (R5). The counter saturates at its maximum. cnt_data shows the counter of the port selected by cnt_sel in the same cycle.
- R10: During and after reset, every out_valid is 0, every in_ready is 1, and every counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPORT | Word-valid flag per input port |
| in_ready | output | NPORT | Accept flag per input port |
| in_word | input | NPORT*72 | Input words; port k is in slice [k*72 +: 72] |
| out_valid | output | NPORT | Word-valid flag per output port |
| out_ready | input | NPORT | Destination-ready flag per output port |
| out_word | output | NPORT*72 | Output words; port k is in slice [k*72 +: 72] |
| cnt_sel | input | 2 | Selects which input port's discard counter is read |
| cnt_data | output | CNT_W | Discard count of the selected port |

## Verification
Two functions can fall in the same cycle.

The first case is forwarding on one lane while other lanes discard and count. To provoke it, the bench drives a one-word packet into the host port and stray non-start words into ports 1 and 3 on the same edge. It then expects exactly one output to become valid and both counters to step by one.

The second case is a release on a stalled output. The held word leaves, and the blocked input word is taken, on the same edge. The bench judges this by the next word seen on that output, while a parallel lane keeps flowing throughout the stall.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
    localparam int WORD_W    = 72;
    localparam int DATA_W    = 64;
    localparam int SOF_BIT   = 64;
    localparam int EOF_BIT   = 65;
    localparam int NB_LSB    = 66;
    localparam int NB_W      = 3;
    localparam int ABORT_BIT = 69;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FRAME   = 2'd1,
        ST_DISCARD = 2'd2
    } lane_st_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_PASS  = 2'd1,
        ACT_DROP  = 2'd2,
        ACT_ABORT = 2'd3
    } lane_act_e;
endpackage

// File: rtl/fsw_errcnt.sv
module fsw_errcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/fsw_lane.sv
module fsw_lane
    import fsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic              drop
);
    lane_st_e          st_q, st_nxt;
    lane_act_e         act;
    logic              fire;
    logic              w_sof, w_eof;
    logic [WORD_W-1:0] abort_word;

    assign in_ready = !out_valid || out_ready;
    assign fire     = in_valid && in_ready;
    assign w_sof    = in_word[SOF_BIT];
    assign w_eof    = in_word[EOF_BIT];

    always_comb begin
        abort_word            = '0;
        abort_word[EOF_BIT]   = 1'b1;
        abort_word[ABORT_BIT] = 1'b1;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // next state and action
    always_comb begin
        act    = ACT_NONE;
        st_nxt = st_q;
        if (fire) begin
            unique case (st_q)
                ST_IDLE, ST_DISCARD: begin
                    if (w_sof) begin
                        act    = ACT_PASS;
                        st_nxt = w_eof ? ST_IDLE : ST_FRAME;
                    end else begin
                        act    = ACT_DROP;
                        st_nxt = ST_DISCARD;
                    end
                end
                ST_FRAME: begin
                    if (w_sof) begin
                        act    = ACT_ABORT;
                        st_nxt = ST_DISCARD;
                    end else begin
                        act    = ACT_PASS;
                        st_nxt = w_eof ? ST_IDLE : ST_FRAME;
                    end
                end
                default: begin
                    act    = ACT_NONE;
                    st_nxt = ST_IDLE;
                end
            endcase
        end
    end

    assign drop = (act == ACT_DROP) || (act == ACT_ABORT);

    // output holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else if (act == ACT_PASS) begin
            out_valid <= 1'b1;
            out_word  <= in_word;
        end else if (act == ACT_ABORT) begin
            out_valid <= 1'b1;
            out_word  <= abort_word;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/fsw_switch.sv
module fsw_switch
    import fsw_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        in_valid,
    output logic [NPORT-1:0]        in_ready,
    input  logic [NPORT*WORD_W-1:0] in_word,
    output logic [NPORT-1:0]        out_valid,
    input  logic [NPORT-1:0]        out_ready,
    output logic [NPORT*WORD_W-1:0] out_word,
    input  logic [$clog2(NPORT)-1:0] cnt_sel,
    output logic [CNT_W-1:0]        cnt_data
);
    localparam int SEL_W = $clog2(NPORT);

    logic [NPORT-1:0] drop;
    logic [CNT_W-1:0] cnt_arr [NPORT];

    for (genvar k = 0; k < NPORT; k++) begin : g_lane
        localparam int DST = (k + 1) % NPORT;

        fsw_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid[k]),
            .in_ready (in_ready[k]),
            .in_word  (in_word[k*WORD_W +: WORD_W]),
            .out_valid(out_valid[DST]),
            .out_ready(out_ready[DST]),
            .out_word (out_word[DST*WORD_W +: WORD_W]),
            .drop     (drop[k])
        );

        fsw_errcnt #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (drop[k]),
            .count(cnt_arr[k])
        );
    end

    always_comb begin
        cnt_data = '0;
        for (int k = 0; k < NPORT; k++) begin
            if (cnt_sel == SEL_W'(k)) cnt_data = cnt_arr[k];
        end
    end
endmodule

// File: rtl/fsw_switch_chk.sv
module fsw_switch_chk
    import fsw_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int CNT_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NPORT-1:0]        in_ready,
    input logic [NPORT-1:0]        out_valid,
    input logic [NPORT-1:0]        out_ready,
    input logic [NPORT*WORD_W-1:0] out_word,
    input logic [$clog2(NPORT)-1:0] cnt_sel,
    input logic [CNT_W-1:0]        cnt_data
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assert_cnt_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $stable(cnt_sel)) |-> (cnt_data >= $past(cnt_data)));

    for (genvar d = 0; d < NPORT; d++) begin : g_out
        localparam int SRC = (d + NPORT - 1) % NPORT;
        logic infr_q;
        logic o_fire;
        assign o_fire = out_valid[d] && out_ready[d];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                infr_q <= 1'b0;
            end else if (o_fire) begin
                if (out_word[d*WORD_W + EOF_BIT])      infr_q <= 1'b0;
                else if (out_word[d*WORD_W + SOF_BIT]) infr_q <= 1'b1;
            end
        end

        assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[d] && !out_ready[d]) |=>
                (out_valid[d] && $stable(out_word[d*WORD_W +: WORD_W])));

        assert_src_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[d] && !out_ready[d]) |-> !in_ready[SRC]);

        assert_src_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!out_valid[d] || out_ready[d]) |-> in_ready[SRC]);

        assert_sof_outside_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (o_fire && out_word[d*WORD_W + SOF_BIT]) |-> !infr_q);

        assert_body_inside_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (o_fire && !out_word[d*WORD_W + SOF_BIT]) |-> infr_q);
    end
endmodule

bind fsw_switch fsw_switch_chk #(.NPORT(NPORT), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_word (out_word),
    .cnt_sel  (cnt_sel),
    .cnt_data (cnt_data)
);

// File: tb/fsw_switch_tb.sv
`timescale 1ns/1ps
module fsw_switch_tb;
    localparam int NP = 4;
    localparam int CW = 4;
    localparam int W  = 72;
    localparam int CMAX = 15;
    localparam logic [W-1:0] ABW = (72'd1 << 65) | (72'd1 << 69);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   in_valid = '0;
    logic [NP-1:0]   in_ready;
    logic [NP*W-1:0] in_word = '0;
    logic [NP-1:0]   out_valid;
    logic [NP-1:0]   out_ready = '1;
    logic [NP*W-1:0] out_word;
    logic [1:0]      cnt_sel = '0;
    logic [CW-1:0]   cnt_data;

    int nchk = 0;
    int nerr = 0;
    int exp_cnt [NP];

    always #2.5 clk = ~clk;

    fsw_switch #(.NPORT(NP), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .cnt_sel(cnt_sel), .cnt_data(cnt_data)
    );

    function automatic logic [W-1:0] mkw(bit sof, bit eof, logic [2:0] nb, logic [63:0] d);
        return {3'b000, nb, eof, sof, d};
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one word on port k, checked one cycle later (R8)
    task automatic xfer(input int k, input logic [W-1:0] w, input bit pass,
                        input logic [W-1:0] expw, input string req);
        int dst;
        logic [NP-1:0] ev;
        dst = (k + 1) % NP;
        @(negedge clk);
        in_valid[k] = 1'b1;
        in_word[k*W +: W] = w;
        @(negedge clk);
        in_valid[k] = 1'b0;
        ev = pass ? NP'(1 << dst) : '0;
        check(out_valid == ev, req, W'(out_valid), W'(ev));
        if (pass) check(out_word[dst*W +: W] == expw, req, out_word[dst*W +: W], expw);
    endtask

    task automatic drop_one(input int k, input logic [W-1:0] w, input string req);
        xfer(k, w, 1'b0, '0, req);
        if (exp_cnt[k] < CMAX) exp_cnt[k]++;
    endtask

    task automatic rdcnt(input int k, input string req);
        cnt_sel = 2'(k);
        #1;
        check(int'(cnt_data) == exp_cnt[k], req, W'(cnt_data), W'(exp_cnt[k]));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [W-1:0] w, wa, wb, wc;
        for (int k = 0; k < NP; k++) exp_cnt[k] = 0;

        // R10: reset state
        repeat (3) @(negedge clk);
        check(out_valid == '0, "R10 out_valid", W'(out_valid), '0);
        check(in_ready == '1, "R10 in_ready", W'(in_ready), W'(4'hF));
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NP; k++) rdcnt(k, "R10 counter");

        // R1/R2/R3: sweep ports and packet lengths
        for (int k = 0; k < NP; k++) begin
            for (int len = 1; len <= 4; len++) begin
                for (int i = 0; i < len; i++) begin
                    bit s, e;
                    s = (i == 0);
                    e = (i == len - 1);
                    w = mkw(s, e, e ? 3'((k + len) % 8) : 3'd0,
                            64'h0123_4567_89AB_CDEF ^ (64'(k) << 48) ^ (64'(len) << 32) ^ (64'(i) * 64'h1111));
                    w[71:70] = 2'(k);
                    xfer(k, w, 1'b1, w, (len == 1) ? "R3 single-word" : "R1 R2 routing");
                end
            end
        end

        // R8: back-to-back on port 2
        for (int i = 0; i <= 4; i++) begin
            @(negedge clk);
            if (i > 0) begin
                w = mkw(i == 1, i == 4, 3'd0, 64'(i - 1) + 64'hA0);
                check(out_valid[3] == 1'b1, "R8 stream valid", W'(out_valid), W'(4'b1000));
                check(out_word[3*W +: W] == w, "R8 stream word", out_word[3*W +: W], w);
            end
            if (i < 4) begin
                in_valid[2] = 1'b1;
                in_word[2*W +: W] = mkw(i == 0, i == 3, 3'd0, 64'(i) + 64'hA0);
            end else begin
                in_valid[2] = 1'b0;
            end
        end

        // R4/R5/R9: framing errors on every port
        for (int k = 0; k < NP; k++) begin
            drop_one(k, mkw(0, 0, 3'd0, 64'hDEAD), "R4 stray word");
            drop_one(k, mkw(0, 1, 3'd2, 64'hBEEF), "R4 discard until sof");
            w = mkw(1, 0, 3'd0, 64'h5000 + 64'(k));
            xfer(k, w, 1'b1, w, "R4 resync on sof");
            w = mkw(0, 0, 3'd0, 64'h5100 + 64'(k));
            xfer(k, w, 1'b1, w, "R4 body passes");
            xfer(k, mkw(1, 0, 3'd0, 64'h7777), 1'b1, ABW, "R5 abort terminator");
            if (exp_cnt[k] < CMAX) exp_cnt[k]++;
            drop_one(k, mkw(0, 0, 3'd0, 64'h8888), "R5 discard after abort");
            w = mkw(1, 1, 3'd5, 64'h5200 + 64'(k));
            xfer(k, w, 1'b1, w, "R5 resync");
            rdcnt(k, "R9 count");
        end

        // concurrent: forward on port 0, discard on ports 1 and 3
        @(negedge clk);
        wa = mkw(1, 1, 3'd1, 64'hC0C0);
        in_valid = 4'b1011;
        in_word[0*W +: W] = wa;
        in_word[1*W +: W] = mkw(0, 0, 3'd0, 64'h1);
        in_word[3*W +: W] = mkw(0, 1, 3'd0, 64'h3);
        @(negedge clk);
        in_valid = '0;
        check(out_valid == 4'b0010, "R1 concurrent valid", W'(out_valid), W'(4'b0010));
        check(out_word[1*W +: W] == wa, "R1 concurrent word", out_word[1*W +: W], wa);
        exp_cnt[1]++;
        exp_cnt[3]++;
        rdcnt(1, "R9 concurrent port1");
        rdcnt(3, "R9 concurrent port3");
        rdcnt(0, "R9 concurrent port0");

        // R6/R7: stall output 1
        out_ready[1] = 1'b0;
        wa = mkw(1, 0, 3'd0, 64'hAAAA);
        xfer(0, wa, 1'b1, wa, "R6 first word");
        wb = mkw(0, 1, 3'd3, 64'hBBBB);
        wc = mkw(1, 1, 3'd4, 64'hCCCC);
        in_valid[0] = 1'b1; in_word[0*W +: W] = wb;
        in_valid[2] = 1'b1; in_word[2*W +: W] = wc;
        #1;
        check(in_ready[0] == 1'b0, "R6 source blocked", W'(in_ready), W'(4'b1110));
        check(in_ready[2] == 1'b1, "R7 other source free", W'(in_ready), W'(4'b0100));
        @(negedge clk);
        in_valid[2] = 1'b0;
        check(out_valid[3] == 1'b1 && out_word[3*W +: W] == wc, "R7 other lane flows", out_word[3*W +: W], wc);
        for (int c = 0; c < 3; c++) begin
            check(out_valid[1] == 1'b1 && out_word[1*W +: W] == wa, "R6 held word", out_word[1*W +: W], wa);
            @(negedge clk);
        end
        out_ready[1] = 1'b1;
        @(negedge clk);
        in_valid[0] = 1'b0;
        check(out_valid[1] == 1'b1 && out_word[1*W +: W] == wb, "R6 release", out_word[1*W +: W], wb);
        @(negedge clk);
        check(out_valid == '0, "R6 drained", W'(out_valid), '0);

        // R9: saturation on port 3
        for (int i = 0; i < 20; i++) drop_one(3, mkw(0, 0, 3'd0, 64'(i)), "R9 drop");
        rdcnt(3, "R9 saturation");
        w = mkw(1, 1, 3'd7, 64'hFEED);
        xfer(3, w, 1'b1, w, "R4 pass after saturation");
        rdcnt(3, "R9 holds at max");

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule